// File: doc/BRIEF.md
# Multi-Mode Serial Receiver With Error Tagging

This block turns an asynchronous serial line into a stream of tagged characters. It runs from a tick that pulses sixteen times per bit period. After a start bit, it collects eight or nine bits, depending on the selected frame format, and then samples the stop bit. Each character is written as a 10-bit word into a 16-entry receive queue. The word carries the received bits together with that character's own parity-error and framing-error flags, so the error is never separated from the data it belongs to.

A host reads the queue through a show-ahead output and a one-cycle read strobe. It watches the not-empty, half-full, full, overrun and idle-timeout status. Five frame formats are supported:
- plain 8-bit;
- 7 bits plus parity;
- 9-bit;
- 8 bits plus a wake-up bit;
- 8 bits plus parity.

Parity is even or odd. A break arrives as a framing-error word whose data bits are all zero. After a framing error, the receiver waits for the line to return high before it looks for a new start bit.

Top module: `serial_rx_tagger`

## Requirements
- R1: With `mode`=3'b001 (and any code not listed below), a frame has 8 data bits sent LSB first, which land in word bits 7:0. Word bit 9 is the framing-error flag. Word bit 8 has no defined meaning in this mode.
- R2: With `mode`=3'b011, a frame has 7 data bits followed by a parity bit. The data lands in word bits 6:0, the received parity bit in word bit 7, and the parity-error flag in word bit 8.
- R3: With `mode`=3'b100 (9-bit data) or 3'b101 (8 bits plus wake-up bit), nine bits follow the start bit. They land in word bits 8:0 in arrival order.
- R4: With `mode`=3'b111, 8 data bits are followed by a parity bit. The data lands in word bits 7:0 and the parity-error flag in word bit 8.
- R5: `odd_par`=1 selects odd parity and `odd_par`=0 selects even parity. The parity-error flag is set when the count of ones over the data and parity bits does not match the selected sense.
- R6: A start bit is accepted only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit produces no word.
- R7: A low line at the middle of the stop bit sets word bit 9. A line held low for the whole frame and beyond gives exactly one word, 10'h200 in mode 3'b001. The receiver then waits for the line to go high before it accepts a new start bit.
- R8: The queue holds 16 words. `rd_word` always shows the oldest word, and `rd_stb` removes it. `not_empty` means at least 1 word is held, `half_full` at least 8, and `full` exactly 16.
- R9: A character that completes while the queue is full is dropped and sets `overrun`. The flag stays set until a read that removes a word, or until `fifo_clr`.
- R10: A `fifo_clr` pulse empties the queue.
- R11: While the queue holds data and the receiver is idle, `timeout` rises after `tmo_limit` bit periods (16 ticks each) with no push and no read. A push, a read or a clear drops it again, and `tmo_limit`=0 disables it.
- R12: While `rx_en` is low, the receiver ignores the line, abandons any partial frame and writes nothing.
- R13: After reset, every status output is low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxd | input | 1 | Serial line, idles high |
| mode | input | 3 | Frame format code |
| odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| rx_en | input | 1 | Receiver enable |
| fifo_clr | input | 1 | One-cycle strobe that empties the queue |
| rd_stb | input | 1 | One-cycle strobe that removes the oldest word |
| tmo_limit | input | 8 | Idle timeout in bit periods, 0 disables |
| rd_word | output | 10 | Oldest queued word: {fe, bit8/pe, bits 7:0} |
| not_empty | output | 1 | Queue holds at least one word |
| half_full | output | 1 | Queue holds at least half its depth |
| full | output | 1 | Queue holds its full depth |
| overrun | output | 1 | Sticky flag for a dropped character |
| timeout | output | 1 | Data has waited unread for the idle limit |

## Verification
The bench builds the block with its default 16-tick bit period and 16-word queue. It drives `tick` every second clock, so one bit lasts 32 clocks. At that rate, 17 back-to-back frames are enough to reach the half-full and full thresholds and to cause an overflow, and a 4-bit-period timeout limit can be bracketed with a few ticks of margin on either side. Random frames cover every format, both parity senses and injected parity and stop-bit errors. Directed cases cover the start-bit glitch, break, disable, clear and both timeout settings.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

    localparam logic [2:0] FMT_8   = 3'b001;
    localparam logic [2:0] FMT_7P  = 3'b011;
    localparam logic [2:0] FMT_9   = 3'b100;
    localparam logic [2:0] FMT_8W  = 3'b101;
    localparam logic [2:0] FMT_8P  = 3'b111;

    localparam int WORD_W = 10;
    localparam int RAW_W  = 9;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    // number of bits between start and stop for a format code
    function automatic logic [3:0] frame_bits(input logic [2:0] fmt);
        logic [3:0] n;
        case (fmt)
            FMT_9, FMT_8W, FMT_8P: n = 4'd9;
            default:               n = 4'd8;
        endcase
        return n;
    endfunction

    // build the queue word from the raw bits (first bit in raw[0])
    function automatic logic [WORD_W-1:0] pack_word(input logic [2:0] fmt,
                                                    input logic [RAW_W-1:0] raw,
                                                    input logic odd,
                                                    input logic fe);
        logic [WORD_W-1:0] w;
        logic pe;
        pe = 1'b0;
        case (fmt)
            FMT_7P: begin
                pe = (^raw[7:0]) ^ odd;
                w  = {fe, pe, raw[7:0]};
            end
            FMT_9, FMT_8W: begin
                w = {fe, raw};
            end
            FMT_8P: begin
                pe = (^raw) ^ odd;
                w  = {fe, pe, raw[7:0]};
            end
            default: begin
                w = {fe, 1'b0, raw[7:0]};
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rxt_frame.sv
module rxt_frame
    import rxt_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic [2:0]        fmt,
    input  logic              odd,
    input  logic              en,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o,
    output logic              busy_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        idx;
        logic [RAW_W-1:0]  sr;
        logic              push;
        logic [WORD_W-1:0] word;
    } frame_s;

    frame_s q, d;
    logic [3:0]       nbits;
    logic [RAW_W-1:0] raw;

    always_comb begin
        nbits = frame_bits(fmt);
        raw   = (nbits == 4'd8) ? {1'b0, q.sr[RAW_W-1:1]} : q.sr;
        d      = q;
        d.push = 1'b0;
        if (!en) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
        end else begin
            case (q.st)
                RX_IDLE: begin
                    if (!line) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (q.cnt == MID_CNT) begin
                            d.cnt = '0;
                            d.idx = '0;
                            d.st  = line ? RX_IDLE : RX_BITS;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_CNT) begin
                            d.sr = {line, q.sr[RAW_W-1:1]};
                            if (q.idx == nbits - 4'd1) begin
                                d.st = RX_STOP;
                            end else begin
                                d.idx = q.idx + 4'd1;
                            end
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_CNT) begin
                            d.word = pack_word(fmt, raw, odd, ~line);
                            d.push = 1'b1;
                            d.st   = line ? RX_IDLE : RX_HOLD;
                        end
                    end
                end
                RX_HOLD: begin
                    if (line) d.st = RX_IDLE;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= RX_IDLE;
            q.cnt  <= '0;
            q.idx  <= '0;
            q.sr   <= '0;
            q.push <= 1'b0;
            q.word <= '0;
        end else begin
            q <= d;
        end
    end

    assign push_o = q.push;
    assign word_o = q.word;
    assign busy_o = (q.st != RX_IDLE);

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o); // R1
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy_o && !push_o)); // R12
    AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_HOLD && !line && en) |=> busy_o); // R7

endmodule

// File: rtl/rxt_fifo.sv
module rxt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         clr,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         half_full,
    output logic         full,
    output logic         overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] HALF_LVL = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wp;
        logic [AW:0]             rp;
        logic                    ovr;
    } fifo_s;

    fifo_s q, d;
    logic [AW:0] level;
    logic        pop_ok, push_ok, drop;

    always_comb begin
        level   = q.wp - q.rp;
        pop_ok  = pop && (level != '0);
        push_ok = push && ((level != FULL_LVL) || pop_ok);
        drop    = push && !push_ok;
        d = q;
        if (clr) begin
            d.wp  = '0;
            d.rp  = '0;
            d.ovr = 1'b0;
        end else begin
            if (push_ok) begin
                d.mem[q.wp[AW-1:0]] = wdata;
                d.wp = q.wp + 1'b1;
            end
            if (pop_ok) begin
                d.rp  = q.rp + 1'b1;
                d.ovr = 1'b0;
            end
            if (drop) d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mem <= '0;
            q.wp  <= '0;
            q.rp  <= '0;
            q.ovr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rdata     = q.mem[q.rp[AW-1:0]];
    assign not_empty = (level != '0);
    assign half_full = (level >= HALF_LVL);
    assign full      = (level == FULL_LVL);
    assign overrun   = q.ovr;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && overrun)); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !pop && !clr) |=> overrun); // R9
    AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && not_empty) |=> !overrun); // R9
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !not_empty); // R10

endmodule

// File: rtl/rxt_idle_timer.sv
module rxt_idle_timer #(
    parameter int OVS   = 16,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             armed,
    input  logic             restart,
    input  logic [LIM_W-1:0] limit,
    output logic             flag_o
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [LIM_W-1:0] bits;
        logic             flag;
    } tmr_s;

    tmr_s q, d;
    logic [LIM_W-1:0] bits_inc;

    always_comb begin
        bits_inc = q.bits + 1'b1;
        d = q;
        if (restart || !armed) begin
            d.sub  = '0;
            d.bits = '0;
            d.flag = 1'b0;
        end else if (tick && !q.flag) begin
            if (q.sub == SUB_LAST) begin
                d.sub  = '0;
                d.bits = bits_inc;
                if ((limit != '0) && (bits_inc == limit)) d.flag = 1'b1;
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sub  <= '0;
            q.bits <= '0;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign flag_o = q.flag;

    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flag_o); // R11
    AST_TMO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> ($past(tick) && $past(limit) != '0)); // R11

endmodule

// File: rtl/serial_rx_tagger.sv
module serial_rx_tagger
    import rxt_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16,
    parameter int LIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [2:0]        mode,
    input  logic              odd_par,
    input  logic              rx_en,
    input  logic              fifo_clr,
    input  logic              rd_stb,
    input  logic [LIM_W-1:0]  tmo_limit,
    output logic [WORD_W-1:0] rd_word,
    output logic              not_empty,
    output logic              half_full,
    output logic              full,
    output logic              overrun,
    output logic              timeout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_s;

    sync_s sy_q, sy_d;

    always_comb begin
        sy_d.s1 = rxd;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.s1 <= 1'b1;
            sy_q.s2 <= 1'b1;
        end else begin
            sy_q <= sy_d;
        end
    end

    logic              fr_push;
    logic [WORD_W-1:0] fr_word;
    logic              fr_busy;

    rxt_frame #(.OVS(OVS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .line   (sy_q.s2),
        .fmt    (mode),
        .odd    (odd_par),
        .en     (rx_en),
        .push_o (fr_push),
        .word_o (fr_word),
        .busy_o (fr_busy)
    );

    rxt_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fr_push),
        .wdata     (fr_word),
        .pop       (rd_stb),
        .clr       (fifo_clr),
        .rdata     (rd_word),
        .not_empty (not_empty),
        .half_full (half_full),
        .full      (full),
        .overrun   (overrun)
    );

    rxt_idle_timer #(.OVS(OVS), .LIM_W(LIM_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .armed   (not_empty && !fr_busy),
        .restart (fr_push || rd_stb || fifo_clr),
        .limit   (tmo_limit),
        .flag_o  (timeout)
    );

    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |=> !timeout); // R11

endmodule

// File: tb/tb_serial_rx_tagger.sv
`timescale 1ns/1ps
module tb_serial_rx_tagger;
    localparam int TICK_DIV = 2;
    localparam int BIT_T    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] mode = 3'b001;
    logic       odd_par = 1'b0;
    logic       rx_en = 1'b1;
    logic       fifo_clr = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] tmo_limit = 8'd0;
    logic [9:0] rd_word;
    logic       not_empty, half_full, full, overrun, timeout;

    int n_chk = 0;
    int n_bad = 0;
    int tdiv = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == 0);
    end

    serial_rx_tagger dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mode(mode),
        .odd_par(odd_par), .rx_en(rx_en), .fifo_clr(fifo_clr), .rd_stb(rd_stb),
        .tmo_limit(tmo_limit), .rd_word(rd_word), .not_empty(not_empty),
        .half_full(half_full), .full(full), .overrun(overrun), .timeout(timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    function automatic int nbits_of(input logic [2:0] m);
        return (m == 3'b100 || m == 3'b101 || m == 3'b111) ? 9 : 8;
    endfunction

    function automatic logic [9:0] exp_word(input logic [2:0] m, input logic [8:0] p,
                                            input logic odd, input logic stop);
        logic fe;
        fe = ~stop;
        case (m)
            3'b011:         return {fe, (^p[7:0]) ^ odd, p[7:0]};
            3'b100, 3'b101: return {fe, p};
            3'b111:         return {fe, (^p) ^ odd, p[7:0]};
            default:        return {fe, 1'b0, p[7:0]};
        endcase
    endfunction

    task automatic send_frame(input logic [8:0] p, input int nb, input logic stop);
        rxd = 1'b0;
        wait_ticks(BIT_T);
        for (int i = 0; i < nb; i++) begin
            rxd = p[i];
            wait_ticks(BIT_T);
        end
        rxd = stop;
        wait_ticks(BIT_T);
        rxd = 1'b1;
        wait_ticks(24);
    endtask

    task automatic read_word(output logic [9:0] w);
        @(negedge clk);
        w = rd_word;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [9:0] w;
        logic [8:0] p;
        logic [2:0] mlist [5];
        void'($urandom(32'd4242));
        mlist = '{3'b001, 3'b011, 3'b100, 3'b101, 3'b111};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 not_empty", 32'(not_empty), 0);
        chk("R13 half_full", 32'(half_full), 0);
        chk("R13 full", 32'(full), 0);
        chk("R13 overrun", 32'(overrun), 0);
        chk("R13 timeout", 32'(timeout), 0);

        // R5 directed parity: 7+parity even, 8+parity odd
        mode = 3'b011; odd_par = 1'b0;
        send_frame(9'h041, 8, 1'b1);
        read_word(w);
        chk("R5 even ok", 32'(w), 32'h041);
        send_frame(9'h0C1, 8, 1'b1);
        read_word(w);
        chk("R5 even bad", 32'(w), 32'h1C1);
        mode = 3'b111; odd_par = 1'b1;
        send_frame(9'h101, 9, 1'b1);
        read_word(w);
        chk("R5 odd bad", 32'(w), 32'h101);
        send_frame(9'h003, 9, 1'b1);
        read_word(w);
        chk("R5 odd bad2", 32'(w), 32'h103);

        // random frames across all formats
        for (int k = 0; k < 40; k++) begin
            logic [2:0] m;
            logic odd, stop, flip;
            int nb;
            string tag;
            m    = mlist[$urandom % 5];
            odd  = 1'($urandom);
            flip = (($urandom % 4) == 0);
            stop = (($urandom % 5) != 0);
            p    = 9'($urandom);
            nb   = nbits_of(m);
            if (m == 3'b001) p[8] = 1'b0;
            if (m == 3'b011) begin p[8] = 1'b0; p[7] = (^p[6:0]) ^ odd ^ flip; end
            if (m == 3'b111) p[8] = (^p[7:0]) ^ odd ^ flip;
            case (m)
                3'b001:         tag = "R1 8-bit";
                3'b011:         tag = "R2 7+par";
                3'b100, 3'b101: tag = "R3 9-bit";
                default:        tag = "R4 8+par";
            endcase
            mode = m; odd_par = odd;
            send_frame(p, nb, stop);
            chk({tag, " present"}, 32'(not_empty), 1);
            read_word(w);
            if (m == 3'b001)
                chk(tag, 32'(w & 10'h2FF), 32'(exp_word(m, p, odd, stop) & 10'h2FF));
            else
                chk(tag, 32'(w), 32'(exp_word(m, p, odd, stop)));
        end

        // R6 short glitch gives no word
        mode = 3'b001; odd_par = 1'b0;
        rxd = 1'b0; wait_ticks(4); rxd = 1'b1; wait_ticks(40);
        chk("R6 glitch", 32'(not_empty), 0);

        // R7 break: line low for long, exactly one word
        rxd = 1'b0; wait_ticks(BIT_T * 14); rxd = 1'b1; wait_ticks(40);
        read_word(w);
        chk("R7 break word", 32'(w), 32'h200);
        chk("R7 single", 32'(not_empty), 0);

        // R12 disabled receiver
        rx_en = 1'b0;
        send_frame(9'h0A5, 8, 1'b1);
        chk("R12 ignored", 32'(not_empty), 0);
        rx_en = 1'b1;
        wait_ticks(4);

        // R8 / R9 thresholds and overrun
        for (int i = 0; i < 17; i++) begin
            send_frame(9'(i + 16), 8, 1'b1);
            if (i == 6) chk("R8 half at 7", 32'(half_full), 0);
            if (i == 7) chk("R8 half at 8", 32'(half_full), 1);
            if (i == 14) chk("R8 full at 15", 32'(full), 0);
            if (i == 15) begin
                chk("R8 full at 16", 32'(full), 1);
                chk("R9 no ovr yet", 32'(overrun), 0);
            end
        end
        chk("R9 overrun set", 32'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            read_word(w);
            chk("R8 order", 32'(w & 10'h0FF), 32'(i + 16));
            if (i == 0) chk("R9 read clears", 32'(overrun), 0);
        end
        chk("R8 drained", 32'(not_empty), 0);

        // R10 clear
        for (int i = 0; i < 3; i++) send_frame(9'h055, 8, 1'b1);
        @(negedge clk); fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
        chk("R10 cleared", 32'(not_empty), 0);

        // R11 timeout
        tmo_limit = 8'd4;
        send_frame(9'h033, 8, 1'b1);
        wait_ticks(24);
        chk("R11 before limit", 32'(timeout), 0);
        wait_ticks(16);
        chk("R11 after limit", 32'(timeout), 1);
        read_word(w);
        chk("R11 read drops", 32'(timeout), 0);
        tmo_limit = 8'd0;
        send_frame(9'h033, 8, 1'b1);
        wait_ticks(100);
        chk("R11 disabled", 32'(timeout), 0);
        read_word(w);

        finish_run();
    end
endmodule